// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This block sequences the two bulk copies of a battery-free nonvolatile SRAM. When a supply-good flag from an external comparator first goes high, the block copies the nonvolatile shadow array into the working SRAM. Normal access is allowed only after that copy. When the flag drops, the block copies the SRAM into the shadow array, if auto-store is enabled and there is something new to save. The copy runs on the charge left in the hold-up capacitor. A host can also request a store or a recall. A bidirectional hardware strobe lets an external agent request a store. The block drives that same strobe low as an open-drain busy signal while it copies.

The arrays sit outside the block. The block steps a copy address through every word, one word per acknowledge on a request/acknowledge handshake, and drives a direction bit. It gates SRAM access through an enable and a write-inhibit output. After every finished copy it keeps access blocked for a fixed number of settling cycles. A dirty flag records whether any write has reached the SRAM since the last copy, and store requests made while the SRAM is clean are skipped.

Top module: `pf_nv_seq`

## Requirements
- R1: While reset is asserted and until power is first seen, the block is off: `busy_o`, `hsb_oe_o`, `copy_req_o` and `sram_en_o` are 0 and `wr_inhibit_o` is 1.
- R2: One cycle after `pwr_ok_i` is seen high while off, a recall starts (`copy_req_o`=1, `copy_dir_o`=0). The recall steps `copy_addr_o` from 0 up to DEPTH-1 and advances one word on each cycle where `copy_req_o` and `copy_ack_i` are both high. After the last word, the SRAM holds the nonvolatile contents.
- R3: After a copy completes with power present, `sram_en_o` stays 0 and `wr_inhibit_o` stays 1 for exactly HOLD_CYC cycles, counted from the first cycle `busy_o` is 0. Access is then allowed.
- R4: If `pwr_ok_i` falls while ready, with `auto_en_i`=1 and the SRAM dirty, a store (`copy_dir_o`=1) starts the next cycle. The store finishes even though power stays low, and the block then goes off with access blocked.
- R5: If `pwr_ok_i` falls while ready and `auto_en_i` is 0 or the SRAM is clean, the block goes off without any copy, and the nonvolatile array is left unchanged.
- R6: While the sensed strobe `hsb_i` is low, `sram_en_o` is 0 and `wr_inhibit_o` is 1 in that same cycle. A low strobe seen while ready and dirty starts a store the next cycle.
- R7: A one-cycle `sw_store_i` pulse while ready and dirty starts a store the next cycle. A `sw_recall_i` pulse while ready starts a recall the next cycle. Either copy leaves the destination array equal to the source array.
- R8: During a store or a recall, `busy_o` and `hsb_oe_o` (drive the strobe low) are 1 and SRAM access is blocked. Outside a copy both are 0.
- R9: If `pwr_ok_i` is low during a recall, the recall is abandoned. On the next cycle `busy_o` and `copy_req_o` are 0 and no store follows.
- R10: A store request from `sw_store_i` or from the strobe, made while no write has been accepted since the last completed copy, is skipped: no copy starts and the block stays ready.
- R11: Whenever `pwr_ok_i` is 0, `wr_inhibit_o` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply above the switch threshold (comparator output) |
| auto_en_i | input | 1 | Enables the automatic store on power loss |
| hsb_i | input | 1 | Sensed level of the open-drain store strobe |
| hsb_oe_o | output | 1 | Pull the strobe low (1 = drive low) |
| cs_i | input | 1 | SRAM chip select from the host |
| wr_i | input | 1 | SRAM write strobe from the host |
| sw_store_i | input | 1 | Software store request, one-cycle pulse |
| sw_recall_i | input | 1 | Software recall request, one-cycle pulse |
| sram_en_o | output | 1 | Gated SRAM enable |
| wr_inhibit_o | output | 1 | Blocks SRAM writes |
| busy_o | output | 1 | A store or a recall is in progress |
| copy_req_o | output | 1 | Copy engine requests a word transfer |
| copy_dir_o | output | 1 | 1 = SRAM to shadow array (store), 0 = shadow to SRAM (recall) |
| copy_addr_o | output | $clog2(DEPTH) | Word address of the current transfer |
| copy_ack_i | input | 1 | Word transferred this cycle |

## Verification
The assertions check on every cycle the access fences: no write while power is low, no enable while the strobe is low, and no access while busy or in the first cycle after a copy. They also check that a word address holds until it is acknowledged and then steps by one, and that a recall ends one cycle after power is lost. The bench scenarios cover everything that depends on history or on array contents. These are: the exact settling-cycle count, the contents of both arrays after each kind of copy, the skipping of clean stores, the recall abort leaving the shadow array intact, and the difference between power loss with and without auto-store.

// File: rtl/pf_nv_pkg.sv
package pf_nv_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RECALL,
    ST_STORE,
    ST_HOLD,
    ST_READY
  } pf_state_e;
endpackage

// File: rtl/nv_copy_engine.sv
module nv_copy_engine #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ack_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_q <= '0;
    else if (!run_i)           addr_q <= '0;
    else if (ack_i)            addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign done_o = run_i && ack_i && (addr_q == LAST);
endmodule

// File: rtl/pf_holdoff.sv
module pf_holdoff #(
  parameter int HOLD_CYC = 4,
  localparam int CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= CW'(HOLD_CYC - 1);
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pf_dirty.sv
module pf_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_q <= 1'b0;
    else if (clr_i)  dirty_q <= 1'b0;
    else if (set_i)  dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/pf_nv_seq.sv
module pf_nv_seq
  import pf_nv_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HOLD_CYC = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_ok_i,
  input  logic          auto_en_i,
  input  logic          hsb_i,
  output logic          hsb_oe_o,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          sw_store_i,
  input  logic          sw_recall_i,
  output logic          sram_en_o,
  output logic          wr_inhibit_o,
  output logic          busy_o,
  output logic          copy_req_o,
  output logic          copy_dir_o,
  output logic [AW-1:0] copy_addr_o,
  input  logic          copy_ack_i
);
  pf_state_e state_q, state_d;
  logic      run, done, hold_zero, hold_load, dirty, access_ok, wr_fire;

  assign run       = (state_q == ST_RECALL) || (state_q == ST_STORE);
  assign access_ok = (state_q == ST_READY) && pwr_ok_i && hsb_i;
  assign wr_fire   = access_ok && cs_i && wr_i;
  assign hold_load = (state_d == ST_HOLD) && (state_q != ST_HOLD);

  nv_copy_engine #(.DEPTH(DEPTH)) u_copy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ack_i  (copy_ack_i),
    .addr_o (copy_addr_o),
    .done_o (done)
  );

  pf_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hold_load),
    .en_i   (state_q == ST_HOLD),
    .zero_o (hold_zero)
  );

  pf_dirty u_dirty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr_fire),
    .clr_i   (done),
    .dirty_o (dirty)
  );

  // priority in READY: power loss, strobe, software store, software recall
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (pwr_ok_i) state_d = ST_RECALL;
      ST_RECALL: begin
        if (!pwr_ok_i)  state_d = ST_OFF;
        else if (done)  state_d = ST_HOLD;
      end
      ST_STORE:  if (done) state_d = pwr_ok_i ? ST_HOLD : ST_OFF;
      ST_HOLD: begin
        if (!pwr_ok_i)      state_d = ST_OFF;
        else if (hold_zero) state_d = ST_READY;
      end
      ST_READY: begin
        if (!pwr_ok_i)               state_d = (auto_en_i && dirty) ? ST_STORE : ST_OFF;
        else if (!hsb_i)             state_d = dirty ? ST_STORE : ST_READY;
        else if (sw_store_i && dirty) state_d = ST_STORE;
        else if (sw_recall_i)        state_d = ST_RECALL;
      end
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign busy_o       = run;
  assign hsb_oe_o     = run;
  assign copy_req_o   = run;
  assign copy_dir_o   = (state_q == ST_STORE);
  assign sram_en_o    = access_ok && cs_i;
  assign wr_inhibit_o = !access_ok;
endmodule

// File: rtl/pf_nv_seq_chk.sv
module pf_nv_seq_chk #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_ok_i,
  input logic          hsb_i,
  input logic          copy_ack_i,
  input logic          copy_req_o,
  input logic          copy_dir_o,
  input logic [AW-1:0] copy_addr_o,
  input logic          busy_o,
  input logic          hsb_oe_o,
  input logic          sram_en_o,
  input logic          wr_inhibit_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_NO_WRITE_LOW_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> wr_inhibit_o); // R11

  AST_STROBE_FENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsb_i |-> (!sram_en_o && wr_inhibit_o)); // R6

  AST_BUSY_FENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (hsb_oe_o && copy_req_o && !sram_en_o && wr_inhibit_o)); // R8

  AST_HOLDOFF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!sram_en_o && wr_inhibit_o)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_req_o && !copy_ack_i) |=> (!copy_req_o || $stable(copy_addr_o))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_req_o && copy_ack_i && copy_addr_o != LAST)
      |=> (!copy_req_o || copy_addr_o == $past(copy_addr_o) + 1'b1)); // R2

  AST_RECALL_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !copy_dir_o && !pwr_ok_i) |=> !busy_o); // R9
endmodule

bind pf_nv_seq pf_nv_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_ok_i     (pwr_ok_i),
  .hsb_i        (hsb_i),
  .copy_ack_i   (copy_ack_i),
  .copy_req_o   (copy_req_o),
  .copy_dir_o   (copy_dir_o),
  .copy_addr_o  (copy_addr_o),
  .busy_o       (busy_o),
  .hsb_oe_o     (hsb_oe_o),
  .sram_en_o    (sram_en_o),
  .wr_inhibit_o (wr_inhibit_o)
);

// File: tb/pf_nv_seq_tb.sv
module pf_nv_seq_tb;
  localparam int DEPTH    = 16;
  localparam int HOLD_CYC = 4;
  localparam int AW       = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_ok_i = 1'b0, auto_en_i = 1'b1, ext_low = 1'b0;
  logic cs_i = 1'b1, wr_i = 1'b0, sw_store_i = 1'b0, sw_recall_i = 1'b0;
  logic copy_ack_i = 1'b0;
  logic hsb_i, hsb_oe_o, sram_en_o, wr_inhibit_o, busy_o, copy_req_o, copy_dir_o;
  logic [AW-1:0] copy_addr_o;

  int errors = 0, checks = 0;
  int waddr = 0, wdata = 0;
  int words = 0, exp_a = 0;
  bit seq_bad = 0, finished = 0;
  int sram_m [DEPTH];
  int nv_m   [DEPTH];
  int snap   [DEPTH];

  assign hsb_i = !(ext_low || hsb_oe_o);  // open-drain wired line

  always #4 clk = ~clk;

  pf_nv_seq #(.DEPTH(DEPTH), .HOLD_CYC(HOLD_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i), .auto_en_i(auto_en_i),
    .hsb_i(hsb_i), .hsb_oe_o(hsb_oe_o), .cs_i(cs_i), .wr_i(wr_i),
    .sw_store_i(sw_store_i), .sw_recall_i(sw_recall_i), .sram_en_o(sram_en_o),
    .wr_inhibit_o(wr_inhibit_o), .busy_o(busy_o), .copy_req_o(copy_req_o),
    .copy_dir_o(copy_dir_o), .copy_addr_o(copy_addr_o), .copy_ack_i(copy_ack_i)
  );

  // array models and handshake bookkeeping
  always @(posedge clk) begin
    if (copy_req_o && copy_ack_i) begin
      if (int'(copy_addr_o) != exp_a) seq_bad = 1'b1;
      if (copy_dir_o) nv_m[copy_addr_o] = sram_m[copy_addr_o];
      else            sram_m[copy_addr_o] = nv_m[copy_addr_o];
      exp_a++;
      words++;
    end
    if (!copy_req_o) exp_a = 0;
    if (sram_en_o && !wr_inhibit_o && wr_i) sram_m[waddr] = wdata;
  end

  // random acknowledge latency
  always @(posedge clk) begin
    #1;
    copy_ack_i = copy_req_o && ($urandom % 3 != 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int diff_cnt();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (sram_m[i] != nv_m[i]) n++;
    return n;
  endfunction

  function automatic int snap_diff();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (snap[i] != nv_m[i]) n++;
    return n;
  endfunction

  task automatic take_snap();
    for (int i = 0; i < DEPTH; i++) snap[i] = nv_m[i];
  endtask

  task automatic wr_word(input int a, input int d);
    @(posedge clk); #1;
    waddr = a; wdata = d; wr_i = 1'b1;
    @(posedge clk); #1;
    wr_i = 1'b0;
  endtask

  task automatic rand_writes(input int n);
    for (int k = 0; k < n; k++) wr_word($urandom % DEPTH, $urandom % 256);
  endtask

  // called at a negedge where busy_o is 1
  task automatic wait_copy(input bit measure, output int hold);
    int g = 0;
    while (busy_o && g < 5000) begin g++; @(negedge clk); end
    hold = 0;
    if (measure) while (!sram_en_o && hold < 200) begin hold++; @(negedge clk); end
  endtask

  task automatic power_up(input string tag);
    int h;
    words = 0; seq_bad = 0;
    @(posedge clk); #1; pwr_ok_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busy_o && !copy_dir_o, {tag, " R2 recall start"}, busy_o, 1);
    wait_copy(1'b1, h);
    chk(words == DEPTH && !seq_bad, {tag, " R2 word count/order"}, words, DEPTH);
    chk(diff_cnt() == 0, {tag, " R2 sram equals shadow"}, diff_cnt(), 0);
    chk(h == HOLD_CYC, {tag, " R3 holdoff cycles"}, h, HOLD_CYC);
  endtask

  // store triggered; called right after the trigger drive, checks start and result
  task automatic expect_store(input string tag, input bit measure);
    int h;
    chk(busy_o && copy_dir_o && hsb_oe_o && !hsb_i, {tag, " R8 store busy/strobe"}, busy_o, 1);
    wait_copy(measure, h);
    chk(words == DEPTH && !seq_bad, {tag, " store word count"}, words, DEPTH);
    chk(diff_cnt() == 0, {tag, " shadow equals sram"}, diff_cnt(), 0);
    if (measure) chk(h == HOLD_CYC, {tag, " R3 holdoff"}, h, HOLD_CYC);
  endtask

  task automatic no_copy_for(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (busy_o) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    int h;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) begin
      nv_m[i] = $urandom % 256;
      sram_m[i] = 1000 + i;
    end

    // reset, power absent
    repeat (3) @(negedge clk);
    chk(!busy_o && !hsb_oe_o && !copy_req_o && !sram_en_o && wr_inhibit_o,
        "R1 reset state", busy_o, 0);
    @(posedge clk); #1; rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !sram_en_o && wr_inhibit_o, "R1 off without power", sram_en_o, 0);

    power_up("first");

    // clean store requests are skipped
    @(posedge clk); #1; sw_store_i = 1'b1;
    @(posedge clk); #1; sw_store_i = 1'b0;
    no_copy_for(5, "R10 clean sw store skipped");
    chk(sram_en_o, "R10 still ready after clean request", sram_en_o, 1);

    @(posedge clk); #1; ext_low = 1'b1;
    @(negedge clk);
    chk(!sram_en_o && wr_inhibit_o, "R6 strobe fences access", sram_en_o, 0);
    no_copy_for(4, "R10 clean strobe skipped");
    @(posedge clk); #1; ext_low = 1'b0;
    @(negedge clk);
    chk(sram_en_o && !wr_inhibit_o, "R6 access back after strobe release", sram_en_o, 1);

    // software store with dirty data
    rand_writes(5);
    chk(diff_cnt() != 0, "R7 writes reached sram", diff_cnt(), 1);
    words = 0; seq_bad = 0;
    @(posedge clk); #1; sw_store_i = 1'b1;
    @(posedge clk); #1; sw_store_i = 1'b0;
    @(negedge clk);
    expect_store("R7 sw store", 1'b1);

    // strobe-requested store
    rand_writes(3);
    words = 0; seq_bad = 0;
    @(posedge clk); #1; ext_low = 1'b1;
    @(negedge clk);
    chk(!sram_en_o && wr_inhibit_o, "R6 strobe fence dirty", sram_en_o, 0);
    @(posedge clk); #1; ext_low = 1'b0;
    @(negedge clk);
    expect_store("R6 strobe store", 1'b1);

    // software recall
    for (int i = 0; i < DEPTH; i++) nv_m[i] = $urandom % 256;
    rand_writes(2);
    words = 0; seq_bad = 0;
    @(posedge clk); #1; sw_recall_i = 1'b1;
    @(posedge clk); #1; sw_recall_i = 1'b0;
    @(negedge clk);
    chk(busy_o && !copy_dir_o && hsb_oe_o, "R7 sw recall start", busy_o, 1);
    wait_copy(1'b1, h);
    chk(words == DEPTH && diff_cnt() == 0, "R7 sw recall contents", diff_cnt(), 0);
    chk(h == HOLD_CYC, "R3 holdoff after recall", h, HOLD_CYC);

    // auto store on power loss
    rand_writes(4);
    words = 0; seq_bad = 0;
    @(posedge clk); #1; pwr_ok_i = 1'b0;
    @(negedge clk);
    chk(wr_inhibit_o && !sram_en_o, "R11 write inhibit on low supply", wr_inhibit_o, 1);
    @(negedge clk);
    expect_store("R4 auto store", 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy_o && !sram_en_o && wr_inhibit_o, "R4 off after auto store", sram_en_o, 0);

    // auto store disabled
    power_up("second");
    rand_writes(4);
    take_snap();
    auto_en_i = 1'b0;
    @(posedge clk); #1; pwr_ok_i = 1'b0;
    no_copy_for(6, "R5 no store when auto disabled");
    chk(snap_diff() == 0, "R5 shadow unchanged", snap_diff(), 0);
    auto_en_i = 1'b1;

    // recall aborted by power loss
    take_snap();
    words = 0;
    @(posedge clk); #1; pwr_ok_i = 1'b1;
    begin
      int g = 0;
      while (words < 3 && g < 500) begin g++; @(negedge clk); end
    end
    @(posedge clk); #1; pwr_ok_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!busy_o && !copy_req_o && !hsb_oe_o, "R9 recall abort clears busy", busy_o, 0);
    no_copy_for(6, "R9 no store after abort");
    chk(snap_diff() == 0, "R9 shadow unchanged after abort", snap_diff(), 0);

    // clean power loss
    power_up("third");
    take_snap();
    @(posedge clk); #1; pwr_ok_i = 1'b0;
    no_copy_for(6, "R5 clean power loss skips store");
    chk(snap_diff() == 0, "R5 shadow unchanged when clean", snap_diff(), 0);

    // random mix of store triggers
    for (int r = 0; r < 8; r++) begin
      int t;
      power_up("rand");
      rand_writes(1 + $urandom % 8);
      t = $urandom % 3;
      words = 0; seq_bad = 0;
      @(posedge clk); #1;
      if (t == 0) sw_store_i = 1'b1;
      else if (t == 1) ext_low = 1'b1;
      else pwr_ok_i = 1'b0;
      @(posedge clk); #1;
      sw_store_i = 1'b0; ext_low = 1'b0;
      @(negedge clk);
      expect_store(t == 0 ? "R7 rand sw" : (t == 1 ? "R6 rand strobe" : "R4 rand power"), 1'b0);
      if (t != 2) begin
        @(posedge clk); #1; pwr_ok_i = 1'b0;
      end
      repeat (4) @(negedge clk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule